// File: doc/BRIEF.md
# Three-Layer Priority Line Compositor

This block builds one display line of output pixels from three framebuffer layers that live in a shared video memory. Each layer has its own base address and all three share a single line pitch. When a line is requested, the block works out the starting word address of each layer for the requested row and column. It then walks across the line, issuing one read per layer per cycle. As the words come back, it chooses one colour per pixel.

Every stored word holds a 15-bit RGB555 colour in bits 14:0, with red in bits 14:10, green in bits 9:5 and blue in bits 4:0. Bit 15 is an opacity flag. Layer 0 wins over layer 1, and layer 1 wins over layer 2. Among the layers whose flag is set, the lowest-numbered one supplies the colour. If no layer is opaque, the pixel is black. The flag is always cleared in the output word.

The video memory is external and has synchronous reads: data requested in one cycle is on the read-data inputs in the next cycle. The output stream runs at one pixel per cycle. A last marker goes with the final pixel, and a one-cycle completion pulse follows it.

Top module: `layer_compositor`

## Requirements
- R1: While reset is held, `rdEn`, `pixValid`, `pixLast` and `lineDone` are all low.
- R2: A start seen while idle latches the configuration. In each of the next `lineWidth` cycles, `rdEn` is high and each `rdAddrN` equals `baseN + startY*linePitch + startX + i` (modulo 2^ADDR_W) for pixel i = 0, 1, .... `rdEn` is low in every other cycle.
- R3: Pixel i appears on `pixData` with `pixValid` high exactly two cycles after the cycle in which it was read. `pixLast` is high only with the final pixel of a line.
- R4: When layer 0 has bit 15 set, the output pixel is layer 0's bits 14:0, whatever layers 1 and 2 hold.
- R5: When layer 0 has bit 15 clear, the output is taken from layer 1 if layer 1 is opaque, and otherwise from layer 2 if layer 2 is opaque.
- R6: When none of the three words has bit 15 set, the output pixel is 0.
- R7: Bit 15 of `pixData` is 0 whenever `pixValid` is high.
- R8: `lineDone` is high for exactly one cycle, the cycle after the last pixel of a line, and never together with `pixValid`.
- R9: A start with `lineWidth` equal to 0 produces no reads and no pixels. `lineDone` pulses three cycles after the edge that accepted the start.
- R10: A start that arrives while reads of a line are still being issued is ignored. The addresses, pixel count and completion of the running line are unchanged.
- R11: A new start is accepted in the cycle right after the last read of a line. Its reads then overlap the previous line's final pixels and completion pulse.
- R12: Changing the base, pitch, position or width inputs after a start has been accepted has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Line request strobe |
| base0 | input | ADDR_W | Word address of layer 0 origin |
| base1 | input | ADDR_W | Word address of layer 1 origin |
| base2 | input | ADDR_W | Word address of layer 2 origin |
| linePitch | input | PITCH_W | Words per framebuffer row, shared by all layers |
| startX | input | COORD_W | First column of the line |
| startY | input | COORD_W | Row index of the line |
| lineWidth | input | COORD_W | Number of pixels in the line |
| rdEn | output | 1 | Read request to video memory, all three ports |
| rdAddr0 | output | ADDR_W | Layer 0 read address |
| rdAddr1 | output | ADDR_W | Layer 1 read address |
| rdAddr2 | output | ADDR_W | Layer 2 read address |
| rdData0 | input | 16 | Layer 0 word, one cycle after the request |
| rdData1 | input | 16 | Layer 1 word, one cycle after the request |
| rdData2 | input | 16 | Layer 2 word, one cycle after the request |
| pixValid | output | 1 | Output pixel valid |
| pixData | output | 16 | Composited RGB555 pixel, bit 15 zero |
| pixLast | output | 1 | Final pixel of the line |
| lineDone | output | 1 | Line complete pulse |

## Verification
Two things can fall in the same cycle: reads for a newly accepted line, and the last pixels and completion pulse of the line before it. Zero-width requests can also land in that window. The bench provokes this by placing a start exactly in the first idle cycle after a line's final read. It also places a start one cycle earlier, in the last read cycle, where it must be ignored. It then chains zero-width and normal requests back to back. A behavioural model predicts, for each cycle, the addresses, every pixel and each completion pulse. That prediction is compared on every clock, so a merged, lost or early pulse, or a read address from the wrong line, shows up in the exact cycle it occurs.

// File: rtl/comp_pkg.sv
package comp_pkg;
  localparam int NUM_LAYERS = 3;
  localparam int PIX_W      = 16;
  localparam int OPQ_BIT    = PIX_W - 1;

  typedef struct packed {
    logic load;       // accept request, compute row origin
    logic issue;      // read one word per layer this cycle
    logic issueLast;  // this read is the final one of the line
    logic emptyMark;  // zero-width request: completion marker only
  } ctrl_s;
endpackage

// File: rtl/comp_ctrl.sv
module comp_ctrl
  import comp_pkg::*;
#(
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [COORD_W-1:0] lineWidth,
  output ctrl_s              ctl
);
  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e             state;
  logic [COORD_W-1:0] remCnt;

  always_comb begin
    ctl           = '0;
    ctl.load      = (state == ST_IDLE) && start;
    ctl.emptyMark = ctl.load && (lineWidth == '0);
    ctl.issue     = (state == ST_RUN);
    ctl.issueLast = ctl.issue && (remCnt == COORD_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      remCnt <= '0;
    end else if (ctl.load && !ctl.emptyMark) begin
      state  <= ST_RUN;
      remCnt <= lineWidth;
    end else if (ctl.issue) begin
      remCnt <= remCnt - COORD_W'(1);
      if (ctl.issueLast) state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/comp_datapath.sv
module comp_datapath
  import comp_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int COORD_W = 10,
  parameter int PITCH_W = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_s              ctl,
  input  logic [ADDR_W-1:0]  baseArr   [NUM_LAYERS],
  input  logic [PITCH_W-1:0] linePitch,
  input  logic [COORD_W-1:0] startX,
  input  logic [COORD_W-1:0] startY,
  input  logic [PIX_W-1:0]   rdDataArr [NUM_LAYERS],
  output logic [ADDR_W-1:0]  rdAddrArr [NUM_LAYERS],
  output logic               rdEn,
  output logic               pixValid,
  output logic [PIX_W-1:0]   pixData,
  output logic               pixLast,
  output logic               lineDone
);
  logic [ADDR_W-1:0] rowOrigin;
  logic              s1Valid, s1Last, s1Empty, s2Empty;
  logic [PIX_W-1:0]  picked;

  assign rowOrigin = ADDR_W'(startY) * ADDR_W'(linePitch) + ADDR_W'(startX);
  assign rdEn      = ctl.issue;

  for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_layer
    logic [ADDR_W-1:0] cursor;
    always_ff @(posedge clk) begin
      if (!rstN)          cursor <= '0;
      else if (ctl.load)  cursor <= baseArr[g] + rowOrigin;
      else if (ctl.issue) cursor <= cursor + ADDR_W'(1);
    end
    assign rdAddrArr[g] = cursor;
  end

  // lowest-numbered opaque layer wins; scan from the weakest upward
  always_comb begin
    picked = '0;
    for (int l = NUM_LAYERS - 1; l >= 0; l--) begin
      if (rdDataArr[l][OPQ_BIT]) picked = {1'b0, rdDataArr[l][OPQ_BIT-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1Last   <= 1'b0;
      s1Empty  <= 1'b0;
      s2Empty  <= 1'b0;
      pixValid <= 1'b0;
      pixLast  <= 1'b0;
      pixData  <= '0;
      lineDone <= 1'b0;
    end else begin
      s1Valid  <= ctl.issue;
      s1Last   <= ctl.issueLast;
      s1Empty  <= ctl.emptyMark;
      s2Empty  <= s1Empty;
      pixValid <= s1Valid;
      pixLast  <= s1Last;
      if (s1Valid) pixData <= picked;
      lineDone <= (pixValid && pixLast) || s2Empty;
    end
  end
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor
  import comp_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int COORD_W = 10,
  parameter int PITCH_W = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [ADDR_W-1:0]  base0,
  input  logic [ADDR_W-1:0]  base1,
  input  logic [ADDR_W-1:0]  base2,
  input  logic [PITCH_W-1:0] linePitch,
  input  logic [COORD_W-1:0] startX,
  input  logic [COORD_W-1:0] startY,
  input  logic [COORD_W-1:0] lineWidth,
  output logic               rdEn,
  output logic [ADDR_W-1:0]  rdAddr0,
  output logic [ADDR_W-1:0]  rdAddr1,
  output logic [ADDR_W-1:0]  rdAddr2,
  input  logic [15:0]        rdData0,
  input  logic [15:0]        rdData1,
  input  logic [15:0]        rdData2,
  output logic               pixValid,
  output logic [15:0]        pixData,
  output logic               pixLast,
  output logic               lineDone
);
  ctrl_s             ctl;
  logic [ADDR_W-1:0] baseArr   [NUM_LAYERS];
  logic [ADDR_W-1:0] rdAddrArr [NUM_LAYERS];
  logic [PIX_W-1:0]  rdDataArr [NUM_LAYERS];

  assign baseArr[0]   = base0;
  assign baseArr[1]   = base1;
  assign baseArr[2]   = base2;
  assign rdDataArr[0] = rdData0;
  assign rdDataArr[1] = rdData1;
  assign rdDataArr[2] = rdData2;
  assign rdAddr0      = rdAddrArr[0];
  assign rdAddr1      = rdAddrArr[1];
  assign rdAddr2      = rdAddrArr[2];

  comp_ctrl #(.COORD_W(COORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lineWidth(lineWidth), .ctl(ctl)
  );

  comp_datapath #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .PITCH_W(PITCH_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .baseArr(baseArr), .linePitch(linePitch),
    .startX(startX), .startY(startY), .rdDataArr(rdDataArr), .rdAddrArr(rdAddrArr),
    .rdEn(rdEn), .pixValid(pixValid), .pixData(pixData), .pixLast(pixLast),
    .lineDone(lineDone)
  );
endmodule

// File: rtl/comp_checker.sv
module comp_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr0,
  input logic [ADDR_W-1:0] rdAddr1,
  input logic [ADDR_W-1:0] rdAddr2,
  input logic [15:0]       rdData0,
  input logic [15:0]       rdData1,
  input logic [15:0]       rdData2,
  input logic              pixValid,
  input logic [15:0]       pixData,
  input logic              pixLast,
  input logic              lineDone
);
  // R3
  pix_follows_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid == $past(rdEn, 2));

  // R3
  last_implies_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixLast |-> pixValid);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && $past(rdEn)) |->
      (rdAddr0 == ADDR_W'($past(rdAddr0) + 1)) &&
      (rdAddr1 == ADDR_W'($past(rdAddr1) + 1)) &&
      (rdAddr2 == ADDR_W'($past(rdAddr2) + 1)));

  // R4
  top_layer_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && $past(rdData0[15])) |-> (pixData == {1'b0, $past(rdData0[14:0])}));

  // R6
  black_when_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !$past(rdData0[15]) && !$past(rdData1[15]) && !$past(rdData2[15]))
      |-> (pixData == 16'h0000));

  // R8
  done_apart_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |-> !pixValid);
endmodule

bind layer_compositor comp_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr0(rdAddr0), .rdAddr1(rdAddr1),
  .rdAddr2(rdAddr2), .rdData0(rdData0), .rdData1(rdData1), .rdData2(rdData2),
  .pixValid(pixValid), .pixData(pixData), .pixLast(pixLast), .lineDone(lineDone)
);

// File: tb/test_layer_compositor.sv
`timescale 1ns/1ps
module test_layer_compositor;
  localparam int AW = 16, CW = 10, PW = 11;

  logic          clk = 1'b0;
  logic          rstN, start;
  logic [AW-1:0] base0, base1, base2;
  logic [PW-1:0] linePitch;
  logic [CW-1:0] startX, startY, lineWidth;
  logic          rdEn, pixValid, pixLast, lineDone;
  logic [AW-1:0] rdAddr0, rdAddr1, rdAddr2;
  logic [15:0]   rdData0, rdData1, rdData2, pixData;

  always #4 clk = ~clk;

  layer_compositor #(.ADDR_W(AW), .COORD_W(CW), .PITCH_W(PW)) i_layer_compositor (
    .clk(clk), .rstN(rstN), .start(start), .base0(base0), .base1(base1), .base2(base2),
    .linePitch(linePitch), .startX(startX), .startY(startY), .lineWidth(lineWidth),
    .rdEn(rdEn), .rdAddr0(rdAddr0), .rdAddr1(rdAddr1), .rdAddr2(rdAddr2),
    .rdData0(rdData0), .rdData1(rdData1), .rdData2(rdData2),
    .pixValid(pixValid), .pixData(pixData), .pixLast(pixLast), .lineDone(lineDone)
  );

  // ---------------- video memory: contents computed from the address
  int memMode = 0;
  function automatic logic [15:0] memWord(input logic [AW-1:0] a);
    logic [31:0] h;
    logic [15:0] w;
    h = {16'h0, a} * 32'd40503 + 32'h1234;
    w = h[23:8];
    case (memMode)
      1: w[15] = 1'b0;
      2: w[15] = 1'b1;
      3: if (a < 16'd8192) w[15] = 1'b0;
      4: begin if (a < 16'd12288) w[15] = 1'b0; else w[15] = 1'b1; end
      default: ;
    endcase
    return w;
  endfunction

  always @(posedge clk) if (rdEn) begin
    rdData0 <= memWord(rdAddr0);
    rdData1 <= memWord(rdAddr1);
    rdData2 <= memWord(rdAddr2);
  end

  // ---------------- reference model
  typedef struct { int cyc; logic [AW-1:0] a0, a1, a2; string tag; } addr_t;
  typedef struct { int cyc; logic [15:0] val; bit last; string tag; } pix_t;
  typedef struct { int cyc; string tag; } done_t;
  addr_t addrQ[$];
  pix_t  pixQ[$];
  done_t doneQ[$];

  int cyc = 0, busyUntil = 0, checks = 0, fails = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rstN && !finished) begin
    bit e;
    e = addrQ.size() > 0 && addrQ[0].cyc == cyc;
    chk(rdEn == e, e ? addrQ[0].tag : "R2", "rdEn", rdEn, e);
    if (e) begin
      chk(rdAddr0 == addrQ[0].a0, addrQ[0].tag, "rdAddr0", rdAddr0, addrQ[0].a0);
      chk(rdAddr1 == addrQ[0].a1, addrQ[0].tag, "rdAddr1", rdAddr1, addrQ[0].a1);
      chk(rdAddr2 == addrQ[0].a2, addrQ[0].tag, "rdAddr2", rdAddr2, addrQ[0].a2);
      void'(addrQ.pop_front());
    end
    e = pixQ.size() > 0 && pixQ[0].cyc == cyc;
    chk(pixValid == e, "R3", "pixValid", pixValid, e);
    if (e) begin
      chk(pixData == pixQ[0].val, pixQ[0].tag, "pixData", pixData, pixQ[0].val);
      chk(pixData[15] == 1'b0, "R7", "pixData[15]", pixData[15], 0);
      chk(pixLast == pixQ[0].last, "R3", "pixLast", pixLast, pixQ[0].last);
      void'(pixQ.pop_front());
    end else
      chk(pixLast == 1'b0, "R3", "pixLast idle", pixLast, 0);
    e = doneQ.size() > 0 && doneQ[0].cyc == cyc;
    chk(lineDone == e, e ? doneQ[0].tag : "R8", "lineDone", lineDone, e);
    if (e) void'(doneQ.pop_front());
  end

  // ---------------- stimulus helpers
  task automatic junk();
    base0 = 16'($urandom); base1 = 16'($urandom); base2 = 16'($urandom);
    linePitch = 11'($urandom); startX = 10'($urandom);
    startY = 10'($urandom); lineWidth = 10'($urandom);
  endtask

  task automatic tick();
    @(negedge clk); #1;
    start = 1'b0;
    junk();   // R12: inputs wander once a request has been sampled
  endtask

  task automatic trySt(input int b0, b1, b2, p, x, y, w, input string tag);
    int j;
    start = 1'b1;
    base0 = 16'(b0); base1 = 16'(b1); base2 = 16'(b2);
    linePitch = 11'(p); startX = 10'(x); startY = 10'(y); lineWidth = 10'(w);
    j = cyc;
    if (j >= busyUntil) begin
      for (int i = 0; i < w; i++) begin
        addr_t ar; pix_t pr;
        logic [15:0] w0, w1, w2;
        ar.cyc = j + 1 + i; ar.tag = tag;
        ar.a0 = 16'(b0 + y * p + x + i);
        ar.a1 = 16'(b1 + y * p + x + i);
        ar.a2 = 16'(b2 + y * p + x + i);
        addrQ.push_back(ar);
        w0 = memWord(ar.a0); w1 = memWord(ar.a1); w2 = memWord(ar.a2);
        pr.cyc = j + 3 + i; pr.last = (i == w - 1);
        if (w0[15])      begin pr.val = {1'b0, w0[14:0]}; pr.tag = "R4"; end
        else if (w1[15]) begin pr.val = {1'b0, w1[14:0]}; pr.tag = "R5"; end
        else if (w2[15]) begin pr.val = {1'b0, w2[14:0]}; pr.tag = "R5"; end
        else             begin pr.val = 16'h0;            pr.tag = "R6"; end
        pixQ.push_back(pr);
      end
      begin
        done_t dr;
        dr.cyc = j + 3 + w; dr.tag = (w == 0) ? "R9" : "R8";
        doneQ.push_back(dr);
      end
      busyUntil = j + w + 1;
    end
    tick();
  endtask

  task automatic waitDrain();
    while (addrQ.size() || pixQ.size() || doneQ.size()) tick();
    tick();
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 1'b0; start = 1'b0; junk();
    repeat (4) @(negedge clk);
    // R1
    chk(rdEn == 0, "R1", "rdEn", rdEn, 0);
    chk(pixValid == 0, "R1", "pixValid", pixValid, 0);
    chk(pixLast == 0, "R1", "pixLast", pixLast, 0);
    chk(lineDone == 0, "R1", "lineDone", lineDone, 0);
    #1 rstN = 1'b1;
    tick(); tick();

    // R2 mixed opacity, plain line
    memMode = 0;
    trySt(100, 8300, 12400, 40, 3, 5, 8, "R2"); waitDrain();
    trySt(0, 9000, 13000, 1023, 1022, 1, 1, "R2"); waitDrain();
    // R9 zero width
    trySt(50, 9000, 13000, 40, 0, 0, 0, "R9"); waitDrain();
    // R6 all transparent, R4 all opaque, R5 lower layers
    memMode = 1; trySt(200, 9100, 13100, 64, 7, 2, 16, "R6"); waitDrain();
    memMode = 2; trySt(200, 9100, 13100, 64, 7, 2, 16, "R4"); waitDrain();
    memMode = 3; trySt(300, 9200, 13200, 64, 1, 3, 20, "R5"); waitDrain();
    memMode = 4; trySt(300, 9200, 13200, 64, 1, 3, 20, "R5"); waitDrain();

    // R10 starts during reads, including the last read cycle, are ignored
    memMode = 0;
    trySt(400, 9300, 13300, 30, 2, 4, 12, "R10");
    tick(); tick();
    trySt(5000, 5000, 5000, 1, 1, 1, 3, "R10");
    while (cyc < busyUntil - 1) tick();
    trySt(6000, 6000, 6000, 2, 2, 2, 5, "R10");
    // R11 accepted in the first idle cycle, overlapping the drain
    trySt(700, 9600, 13600, 32, 4, 1, 6, "R11");
    while (cyc < busyUntil) tick();
    trySt(0, 0, 0, 0, 0, 0, 0, "R11");
    trySt(0, 0, 0, 0, 0, 0, 0, "R11");
    trySt(900, 9800, 13800, 16, 0, 7, 4, "R11");
    waitDrain();

    // R12 long line while every input wanders
    trySt(0, 8192, 12288, 0, 0, 0, 1023, "R12"); waitDrain();

    // random requests at random moments
    for (int n = 0; n < 60; n++) begin
      int g;
      g = $urandom_range(0, 3);
      repeat (g) tick();
      trySt($urandom_range(0, 4000), $urandom_range(8192, 12000),
            $urandom_range(12288, 20000), $urandom_range(0, 80),
            $urandom_range(0, 60), $urandom_range(0, 30),
            ($urandom_range(0, 4) == 0) ? 0 : $urandom_range(1, 40), "R11");
    end
    waitDrain();
    finishRun();
  end
endmodule